// File: doc/BRIEF.md
# Management Bus Register Slave

This block is the slave end of a two-wire serial management bus. It samples the shared data line on every rising edge of the management clock. From each frame it pulls out the start and operation codes, a device address, a register address, a turnaround pair and a 16-bit data word. A decoded access is handed to a plain register-file port as a one-cycle write strobe or read strobe, together with the register address and the write data. For a read, the block returns the word on the line. It drives the line only while it sends read data, and uses an output-enable to do so.

Two register blocks hang off the port, and each one answers to its own strapped device address. The slave stays silent until it has seen a long run of idle ones on the line. It falls back to that silent state after any malformed frame. Once it is in step with the bus, a single idle bit between frames is enough. A control bit in the first block can turn on mirroring, so that each write to the first block also lands in the second.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset the slave gives no strobe and never drives the line until it has sampled 32 consecutive ones; frames before that are ignored.
- R2: A frame is start 0,1; opcode 1,0 (read) or 0,1 (write); five device-address bits then five register-address bits, MSB first; two turnaround bits; 16 data bits MSB first. A matching write gives one single-cycle write strobe with that address and data.
- R3: Once synchronised, one idle 1 between frames is enough. A 0 where that idle bit belongs counts as an invalid start.
- R4: On a matching read the line stays undriven in the first turnaround bit. The slave drives 0 in the second turnaround bit and then the 16 data bits MSB first. The read strobe is high for the single cycle of the first turnaround bit.
- R5: The output-enable is dropped on the clock edge after the last read data bit. It is never high outside a read.
- R6: Reading register address 01h returns bit 6 as 1 regardless of the register file value.
- R7: An invalid start (0,0) or an invalid opcode (0,0 or 1,1) returns the slave to the unsynchronised state, which again needs 32 consecutive ones. 31 ones are not enough.
- R8: A write whose turnaround is not 1 then 0 performs no write and forces resynchronisation.
- R9: A frame whose device address matches neither strap gives no strobe and no drive. Frame tracking continues, so a frame one idle bit later is served.
- R10: Port A answers the first strap and port B the second. When bit 15 of port A register 17h was last written as 1, each write to port A also strobes port B. A read strobes exactly one port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| sd_i | input | 1 | Sampled level of the shared data line |
| sd_o | output | 1 | Value the slave drives onto the line |
| sd_oe | output | 1 | Line drive enable |
| addr_a_i | input | 5 | Strapped device address of port A |
| addr_b_i | input | 5 | Strapped device address of port B |
| rf_addr_o | output | 5 | Register address of the current access |
| rf_wdata_o | output | 16 | Write data |
| rf_wr_a_o | output | 1 | Write strobe, port A |
| rf_wr_b_o | output | 1 | Write strobe, port B |
| rf_rd_a_o | output | 1 | Read strobe, port A |
| rf_rd_b_o | output | 1 | Read strobe, port B |
| rf_rdata_a_i | input | 16 | Read data from port A, valid in the read strobe cycle |
| rf_rdata_b_i | input | 16 | Read data from port B, valid in the read strobe cycle |

## Verification
A table of writes with varied data and address patterns is sent back to back, separated by single idle bits. Each word is then read back, which shows that field order, MSB-first shifting and the turnaround drive timing are all correct. Malformed frames (bad start, both bad opcodes, a bad write turnaround, a missing idle bit) are each followed by a well-formed frame that must be ignored. A 31-one run must not resynchronise, while a 32-one run must. A foreign device address must leave the line untouched while the next frame is still served. Mirroring is checked by reading port B after a port A write, both with the control bit set and with it cleared.

// File: rtl/mss_pkg.sv
`timescale 1ns/1ps
package mss_pkg;

    typedef enum logic [3:0] {
        ST_HUNT, ST_IDLE, ST_START, ST_OP, ST_DEV,
        ST_REG, ST_TURN, ST_DATA, ST_GAP
    } mss_state_t;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    localparam int STATUS_REG = 1;
    localparam int STATUS_BIT = 6;
    localparam int MIRROR_REG = 23;
    localparam int MIRROR_BIT = 15;

    function automatic logic op_is_valid(input logic [1:0] op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/mss_frame_fsm.sv
`timescale 1ns/1ps
module mss_frame_fsm
    import mss_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int SYNC_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    output logic              rd_req_o,
    output logic              wr_req_o,
    output logic              hit_a_o,
    output logic              hit_b_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int MAXLEN = (SYNC_LEN > DATA_W) ? SYNC_LEN : DATA_W;
    localparam int CW     = $clog2(MAXLEN) + 1;
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_LEN - 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);

    mss_state_t        state;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] sr;
    logic              op_rd;
    logic              ta_first;
    logic [DATA_W-1:0] sr_next;

    assign sr_next = {sr[DATA_W-2:0], line_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            cnt        <= '0;
            sr         <= '0;
            op_rd      <= 1'b0;
            ta_first   <= 1'b0;
            rd_req_o   <= 1'b0;
            wr_req_o   <= 1'b0;
            hit_a_o    <= 1'b0;
            hit_b_o    <= 1'b0;
            reg_addr_o <= '0;
            wdata_o    <= '0;
        end else begin
            rd_req_o <= 1'b0;
            wr_req_o <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (!line_i) begin
                        cnt <= '0;
                    end else if (cnt == SYNC_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (!line_i) state <= ST_START;
                end
                ST_START: begin
                    cnt   <= '0;
                    state <= line_i ? ST_OP : ST_HUNT;
                end
                ST_OP: begin
                    sr <= sr_next;
                    if (cnt == '0) begin
                        cnt <= 1'b1;
                    end else begin
                        cnt <= '0;
                        if (op_is_valid(sr_next[1:0])) begin
                            op_rd <= (sr_next[1:0] == OP_READ);
                            state <= ST_DEV;
                        end else begin
                            state <= ST_HUNT;
                        end
                    end
                end
                ST_DEV: begin
                    sr <= sr_next;
                    if (cnt == ADDR_LAST) begin
                        cnt     <= '0;
                        hit_a_o <= (sr_next[ADDR_W-1:0] == addr_a_i);
                        hit_b_o <= (sr_next[ADDR_W-1:0] == addr_b_i);
                        state   <= ST_REG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_REG: begin
                    sr <= sr_next;
                    if (cnt == ADDR_LAST) begin
                        cnt        <= '0;
                        reg_addr_o <= sr_next[ADDR_W-1:0];
                        rd_req_o   <= op_rd && (hit_a_o || hit_b_o);
                        state      <= ST_TURN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (cnt == '0) begin
                        ta_first <= line_i;
                        cnt      <= 1'b1;
                    end else begin
                        cnt <= '0;
                        if (!op_rd && !(ta_first && !line_i)) state <= ST_HUNT;
                        else                                   state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    sr <= sr_next;
                    if (cnt == DATA_LAST) begin
                        cnt      <= '0;
                        wdata_o  <= sr_next;
                        wr_req_o <= !op_rd && (hit_a_o || hit_b_o);
                        state    <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    cnt   <= '0;
                    state <= line_i ? ST_IDLE : ST_HUNT;
                end
                default: begin
                    cnt   <= '0;
                    state <= ST_HUNT;
                end
            endcase
        end
    end

endmodule

// File: rtl/mss_write_route.sv
`timescale 1ns/1ps
module mss_write_route
    import mss_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req_i,
    input  logic              rd_req_i,
    input  logic              hit_a_i,
    input  logic              hit_b_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wr_a_o,
    output logic              wr_b_o,
    output logic              rd_a_o,
    output logic              rd_b_o,
    output logic              sel_b_o
);
    localparam logic [ADDR_W-1:0] MIRROR_ADDR = ADDR_W'(MIRROR_REG);

    logic mirror_q;

    assign sel_b_o = hit_b_i && !hit_a_i;
    assign wr_a_o  = wr_req_i && hit_a_i;
    assign wr_b_o  = wr_req_i && (sel_b_o || (hit_a_i && mirror_q));
    assign rd_a_o  = rd_req_i && hit_a_i;
    assign rd_b_o  = rd_req_i && sel_b_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            mirror_q <= 1'b0;
        end else if (wr_a_o && (reg_addr_i == MIRROR_ADDR)) begin
            mirror_q <= wdata_i[MIRROR_BIT];
        end
    end

endmodule

// File: rtl/mss_read_shift.sv
`timescale 1ns/1ps
module mss_read_shift
    import mss_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              sel_b_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] rdata_a_i,
    input  logic [DATA_W-1:0] rdata_b_i,
    output logic              sd_o,
    output logic              sd_oe
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0]     FULL        = CW'(DATA_W);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_REG);

    logic [DATA_W-1:0] fetched;
    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     left;

    always_comb begin
        fetched = sel_b_i ? rdata_b_i : rdata_a_i;
        if (reg_addr_i == STATUS_ADDR) fetched[STATUS_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_o  <= 1'b0;
            sd_oe <= 1'b0;
            sh    <= '0;
            left  <= '0;
        end else if (load_i) begin
            sd_oe <= 1'b1;
            sd_o  <= 1'b0;
            sh    <= fetched;
            left  <= FULL;
        end else if (left != '0) begin
            sd_o <= sh[DATA_W-1];
            sh   <= {sh[DATA_W-2:0], 1'b0};
            left <= left - 1'b1;
        end else begin
            sd_oe <= 1'b0;
            sd_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/mgmt_serial_slave.sv
`timescale 1ns/1ps
module mgmt_serial_slave
    import mss_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 5,
    parameter int SYNC_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sd_i,
    output logic              sd_o,
    output logic              sd_oe,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_wr_a_o,
    output logic              rf_wr_b_o,
    output logic              rf_rd_a_o,
    output logic              rf_rd_b_o,
    input  logic [DATA_W-1:0] rf_rdata_a_i,
    input  logic [DATA_W-1:0] rf_rdata_b_i
);
    logic rd_req, wr_req, hit_a, hit_b, sel_b;

    mss_frame_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_LEN(SYNC_LEN)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .line_i     (sd_i),
        .addr_a_i   (addr_a_i),
        .addr_b_i   (addr_b_i),
        .rd_req_o   (rd_req),
        .wr_req_o   (wr_req),
        .hit_a_o    (hit_a),
        .hit_b_o    (hit_b),
        .reg_addr_o (rf_addr_o),
        .wdata_o    (rf_wdata_o)
    );

    mss_write_route #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_route (
        .clk        (clk),
        .rst        (rst),
        .wr_req_i   (wr_req),
        .rd_req_i   (rd_req),
        .hit_a_i    (hit_a),
        .hit_b_i    (hit_b),
        .reg_addr_i (rf_addr_o),
        .wdata_i    (rf_wdata_o),
        .wr_a_o     (rf_wr_a_o),
        .wr_b_o     (rf_wr_b_o),
        .rd_a_o     (rf_rd_a_o),
        .rd_b_o     (rf_rd_b_o),
        .sel_b_o    (sel_b)
    );

    mss_read_shift #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .load_i     (rd_req),
        .sel_b_i    (sel_b),
        .reg_addr_i (rf_addr_o),
        .rdata_a_i  (rf_rdata_a_i),
        .rdata_b_i  (rf_rdata_b_i),
        .sd_o       (sd_o),
        .sd_oe      (sd_oe)
    );

endmodule

// File: rtl/mss_checker.sv
`timescale 1ns/1ps
module mss_checker #(
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst,
    input logic sd_o,
    input logic sd_oe,
    input logic rf_wr_a_o,
    input logic rf_wr_b_o,
    input logic rf_rd_a_o,
    input logic rf_rd_b_o
);
    localparam logic [7:0] DRIVE_LEN = 8'(DATA_W + 1);

    logic [7:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst)        oe_run <= '0;
        else if (sd_oe) oe_run <= oe_run + 1'b1;
        else            oe_run <= '0;
    end

    p_drive_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_oe) |-> $past(rf_rd_a_o || rf_rd_b_o));

    p_turn_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_oe) |-> (sd_o == 1'b0));

    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (rf_rd_a_o || rf_rd_b_o) |=> !(rf_rd_a_o || rf_rd_b_o));

    p_drive_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_oe) |-> (oe_run == DRIVE_LEN));

    p_quiet_on_write_r5: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_a_o || rf_wr_b_o) |-> !sd_oe);

    p_wr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rf_wr_a_o |=> !rf_wr_a_o);

    p_one_read_port_r10: assert property (@(posedge clk) disable iff (rst)
        !(rf_rd_a_o && rf_rd_b_o));

endmodule

bind mgmt_serial_slave mss_checker #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_o      (sd_o),
    .sd_oe     (sd_oe),
    .rf_wr_a_o (rf_wr_a_o),
    .rf_wr_b_o (rf_wr_b_o),
    .rf_rd_a_o (rf_rd_a_o),
    .rf_rd_b_o (rf_rd_b_o)
);

// File: tb/test_mgmt_serial_slave.sv
`timescale 1ns/1ps
module test_mgmt_serial_slave;

    localparam logic [4:0] ADR_A = 5'h05;
    localparam logic [4:0] ADR_B = 5'h06;
    localparam int NV = 6;
    // {port B select, register, data}
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 5'h02, 16'hA5C3},
        {1'b0, 5'h1F, 16'hFFFF},
        {1'b0, 5'h00, 16'h8001},
        {1'b1, 5'h02, 16'h0000},
        {1'b1, 5'h10, 16'h5A5A},
        {1'b0, 5'h15, 16'h7E81}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drv = 1'b1;
    logic        sd_o, sd_oe;
    logic [4:0]  rf_addr;
    logic [15:0] rf_wdata, rd_a, rd_b;
    logic        wr_a, wr_b, rdq_a, rdq_b;
    logic        line;
    logic [15:0] ra [32];
    logic [15:0] rb [32];
    int          total = 0;
    int          fails = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    assign line = sd_oe ? sd_o : drv;
    assign rd_a = ra[rf_addr];
    assign rd_b = rb[rf_addr];

    always @(posedge clk) begin
        if (wr_a) ra[rf_addr] <= rf_wdata;
        if (wr_b) rb[rf_addr] <= rf_wdata;
    end

    mgmt_serial_slave i_mgmt_serial_slave (
        .clk(clk), .rst(rst), .sd_i(line), .sd_o(sd_o), .sd_oe(sd_oe),
        .addr_a_i(ADR_A), .addr_b_i(ADR_B),
        .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata),
        .rf_wr_a_o(wr_a), .rf_wr_b_o(wr_b), .rf_rd_a_o(rdq_a), .rf_rd_b_o(rdq_b),
        .rf_rdata_a_i(rd_a), .rf_rdata_b_i(rd_b)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic b);
        @(negedge clk);
        drv = b;
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) slot(v[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b1);
    endtask

    task automatic wr_frame(input logic [4:0] dev, input logic [4:0] rg, input logic [15:0] d,
                            input logic [1:0] op, input logic [1:0] ta, input logic gap);
        send(16'b01, 2);
        send({14'd0, op}, 2);
        send({11'd0, dev}, 5);
        send({11'd0, rg}, 5);
        send({14'd0, ta}, 2);
        send(d, 16);
        if (gap) slot(1'b1);
    endtask

    task automatic rd_frame(input logic [4:0] dev, input logic [4:0] rg, output logic [15:0] got,
                            output logic ta_ok, output logic rel_ok, output logic quiet);
        logic early;
        early = 1'b0;
        quiet = 1'b1;
        send(16'b01, 2);
        send(16'b10, 2);
        for (int i = 4; i >= 0; i--) begin slot(dev[i]); #1; early |= sd_oe; end
        for (int i = 4; i >= 0; i--) begin slot(rg[i]);  #1; early |= sd_oe; end
        slot(1'b1); #1;
        ta_ok = !sd_oe && line && !early;
        quiet = quiet && !sd_oe && !early;
        slot(1'b1); #1;
        ta_ok = ta_ok && sd_oe && !line;
        quiet = quiet && !sd_oe;
        for (int i = 15; i >= 0; i--) begin
            slot(1'b1); #1;
            got[i] = line;
            quiet = quiet && !sd_oe;
        end
        slot(1'b1); #1;
        rel_ok = !sd_oe;
        quiet = quiet && !sd_oe;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] dev, input logic [4:0] rg,
                          input logic [15:0] exp);
        logic [15:0] g;
        logic t, r, q;
        rd_frame(dev, rg, g, t, r, q);
        chk(tag, g, exp);
        chk("R4 turnaround Z then 0", {15'd0, t}, 16'd1);
        chk("R5 release after last bit", {15'd0, r}, 16'd1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        logic t, r, q;
        for (int i = 0; i < 32; i++) begin ra[i] = 16'h0; rb[i] = 16'h0; end
        repeat (3) @(negedge clk);
        #1;
        chk("R5 reset: oe low", {15'd0, sd_oe}, 16'd0);
        chk("R1 reset: no strobes", {12'd0, wr_a, wr_b, rdq_a, rdq_b}, 16'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1: a frame before the 32-one preamble is ignored
        idle(2);
        wr_frame(ADR_A, 5'h02, 16'h1234, 2'b01, 2'b10, 1'b1);
        idle(32);
        rd_chk("R1 pre-sync write ignored", ADR_A, 5'h02, 16'h0000);

        // R2/R3: table of writes back to back with one idle bit, then read back
        for (int i = 0; i < NV; i++)
            wr_frame(VEC[i][21] ? ADR_B : ADR_A, VEC[i][20:16], VEC[i][15:0], 2'b01, 2'b10, 1'b1);
        for (int i = 0; i < NV; i++)
            rd_chk("R2 R3 table readback", VEC[i][21] ? ADR_B : ADR_A, VEC[i][20:16], VEC[i][15:0]);

        // R6: status register bit 6 forced
        wr_frame(ADR_A, 5'h01, 16'h1200, 2'b01, 2'b10, 1'b1);
        rd_chk("R6 status bit forced", ADR_A, 5'h01, 16'h1240);

        // R9: foreign address is silent, next frame still served
        rd_frame(5'h03, 5'h02, g, t, r, q);
        chk("R9 foreign read leaves line undriven", {15'd0, q}, 16'd1);
        chk("R9 foreign read line value", g, 16'hFFFF);
        wr_frame(5'h03, 5'h02, 16'hBEEF, 2'b01, 2'b10, 1'b1);
        rd_chk("R9 tracking after foreign frames", ADR_A, 5'h02, 16'hA5C3);

        // R10: mirroring of port A writes into port B
        wr_frame(ADR_A, 5'h17, 16'h8000, 2'b01, 2'b10, 1'b1);
        wr_frame(ADR_A, 5'h09, 16'h5A5A, 2'b01, 2'b10, 1'b1);
        rd_chk("R10 mirrored to B", ADR_B, 5'h09, 16'h5A5A);
        wr_frame(ADR_B, 5'h09, 16'h0F0F, 2'b01, 2'b10, 1'b1);
        rd_chk("R10 B write not copied to A", ADR_A, 5'h09, 16'h5A5A);
        rd_chk("R10 B read single port", ADR_B, 5'h09, 16'h0F0F);
        wr_frame(ADR_A, 5'h17, 16'h0000, 2'b01, 2'b10, 1'b1);
        wr_frame(ADR_A, 5'h0A, 16'h1111, 2'b01, 2'b10, 1'b1);
        rd_chk("R10 mirror off", ADR_B, 5'h0A, 16'h0000);
        rd_chk("R10 A still written", ADR_A, 5'h0A, 16'h1111);

        // R7: invalid opcodes
        wr_frame(ADR_A, 5'h03, 16'h7777, 2'b11, 2'b10, 1'b1);
        wr_frame(ADR_A, 5'h03, 16'h3333, 2'b01, 2'b10, 1'b1);
        idle(32);
        rd_chk("R7 opcode 11 resync", ADR_A, 5'h03, 16'h0000);
        wr_frame(ADR_A, 5'h03, 16'h7777, 2'b00, 2'b10, 1'b1);
        wr_frame(ADR_A, 5'h03, 16'h3333, 2'b01, 2'b10, 1'b1);
        idle(32);
        rd_chk("R7 opcode 00 resync", ADR_A, 5'h03, 16'h0000);

        // R7: invalid start, then 31 ones are not enough
        slot(1'b0); slot(1'b0);
        wr_frame(ADR_A, 5'h04, 16'h4444, 2'b01, 2'b10, 1'b0);
        idle(31);
        wr_frame(ADR_A, 5'h04, 16'h4545, 2'b01, 2'b10, 1'b1);
        idle(32);
        rd_chk("R7 bad start and 31 ones", ADR_A, 5'h04, 16'h0000);

        // R3: missing idle bit between frames
        wr_frame(ADR_A, 5'h0B, 16'h2222, 2'b01, 2'b10, 1'b0);
        wr_frame(ADR_A, 5'h0B, 16'h3333, 2'b01, 2'b10, 1'b1);
        idle(32);
        rd_chk("R3 missing idle bit", ADR_A, 5'h0B, 16'h2222);

        // R8: bad write turnaround
        wr_frame(ADR_A, 5'h0C, 16'h6666, 2'b01, 2'b11, 1'b1);
        wr_frame(ADR_A, 5'h0C, 16'h6767, 2'b01, 2'b10, 1'b1);
        idle(32);
        rd_chk("R8 bad turnaround", ADR_A, 5'h0C, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule